// File: doc/BRIEF.md
# Buffered Input Capture Channel

This block timestamps transitions on one input pin. The pin passes through a two-flop synchronizer and an optional delay filter that rejects short pulses. A qualifying transition then copies the free-running timer value `count_i` into a capture register. A second register, the holding register, extends the channel to two entries. It fills in one of two ways. In queue mode every accepted capture first pushes the previous capture value into the holding register. In latch mode the holding register is loaded only on an external strobe or on a software force command.

A no-overwrite option protects unread values. A flag-mode option moves the status flag from "every capture" to "every transfer into the holding register". A polarity bit records the direction of the last captured transition. Software reaches the channel through a simple register port. Reads take no wait states, and the read data is combinational from the address.

Top module: `cap_channel`

## Requirements
- R1: After reset, the capture register, holding register, flag, interrupt request and polarity bit read 0. The control register (address 0) reads 0, which selects edge code 00 (capture off).
- R2: Control bits [1:0] select the capture condition: 00 no capture, 01 rising transitions only, 10 falling transitions only, 11 both.
- R3: With the filter off, a pin change applied before clock edge k is captured at edge k+2, storing the `count_i` value sampled at that edge. The flag (status register, address 1, bit 0, also `flag_o`) is set.
- R4: `irq_o` is high exactly when the flag is set and the interrupt enable (control bit 2) is 1.
- R5: In queue mode (control bit 3 = 0), an accepted capture moves the old capture value into the holding register in the same cycle that the new value is written.
- R6: In latch mode (control bit 3 = 1), captures leave the holding register untouched. It loads the capture value only on a one-cycle pulse of `latch_stb_i`, or on a write of 1 to bit 0 of the command register (address 2).
- R7: Control bits [8:7] set the filter: 00 off, 01 256 cycles, 10 512 cycles, 11 1024 cycles. A level held for fewer cycles than the setting is ignored. A held level is captured L+2 cycles after the pin change, where L is the setting.
- R8: With no-overwrite (control bit 4) in queue mode, a capture is dropped while both registers hold unread values. Reading the capture register (address 3) or the holding register (address 4) frees that register.
- R9: With flag mode (control bit 5) in queue mode, the flag is set only by a transfer into the holding register. A capture into an empty capture register with no transfer leaves the flag clear.
- R10: The polarity bit (`pol_o`, status bit 1) is 1 after a rising capture and 0 after a falling capture.
- R11: Writing 1 to status bit 0 clears the flag, and writing 0 has no effect. With fast clear (control bit 6), reading the capture register also clears the flag. Without fast clear, that read leaves the flag set.
- R12: When a capture and a latch strobe fall in the same cycle, the holding register takes the old capture value and the capture register takes the new one. A flag set and a flag clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous event pin |
| count_i | input | 16 | Free-running timer value |
| latch_stb_i | input | 1 | Latch-mode transfer strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_re_i | input | 1 | Register read strobe (drives read side effects) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| cap_o | output | 16 | Capture register |
| hold_o | output | 16 | Holding register |
| flag_o | output | 1 | Channel status flag |
| irq_o | output | 1 | Interrupt request |
| pol_o | output | 1 | Polarity of last captured transition |

## Verification
Two cases are driven into the same cycle. The first is a capture and a latch-mode transfer. The second is a flag-clear write and a flag set. The bench changes the pin two negative edges before it raises the strobe and writes 1 to status bit 0, so that all three act at the capture edge. The result is correct only if the holding register shows the previous capture value, the capture register shows the new timestamp, and the flag stays set.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic [1:0] dly;
    logic       fast_clr;
    logic       flag_mode;
    logic       no_ovw;
    logic       latch_mode;
    logic       irq_en;
    edge_sel_e  edge_sel;
  } ctrl_t;

  localparam int CTRL_W   = $bits(ctrl_t);
  localparam int ADR_CTRL = 0;
  localparam int ADR_STAT = 1;
  localparam int ADR_CMD  = 2;
  localparam int ADR_CAP  = 3;
  localparam int ADR_HOLD = 4;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

  for (genvar i = 1; i < STAGES; i++) begin : g_chk
    // R3: each stage adds exactly one cycle
    a_r3_sync_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chain_q[i] == $past(chain_q[i-1]));
  end
endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
  parameter int BASE = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] dly_i,
  input  logic       lvl_i,
  output logic       lvl_o
);
  localparam int CW = $clog2(BASE * 4);

  logic          en;
  logic          acc_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;

  assign en = (dly_i != 2'b00);

  always_comb begin
    case (dly_i)
      2'd1:    lim_m1 = CW'(BASE - 1);
      2'd2:    lim_m1 = CW'(BASE * 2 - 1);
      default: lim_m1 = CW'(BASE * 4 - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      cnt_q <= '0;
    end else if (!en) begin
      acc_q <= lvl_i;
      cnt_q <= '0;
    end else if (lvl_i == acc_q) begin
      cnt_q <= '0;             // level fell back: pulse rejected
    end else if (cnt_q == lim_m1) begin
      acc_q <= lvl_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = en ? acc_q : lvl_i;

  // R7: accepted level only moves once the window has fully elapsed
  a_r7_accept_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && $past(en) && (acc_q != $past(acc_q))) |-> ($past(cnt_q) == $past(lim_m1)));

  // R7: a return to the accepted level restarts the window
  a_r7_short_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && (lvl_i == acc_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det
  import cap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  edge_sel_e sel_i,
  output logic      hit_o,
  output logic      rise_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    case (sel_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_ANY:  hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end

  assign rise_o = rise;
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DLY_BASE    = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              latch_stb_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic [CNT_W-1:0]  hold_o,
  output logic              flag_o,
  output logic              irq_o,
  output logic              pol_o
);
  logic [CNT_W-1:0] ctrl_raw_q;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cap_q, hold_q;
  logic             cap_full_q, hold_full_q;
  logic             flag_q, pol_q;

  logic pin_s, pin_f, hit, rise;
  logic queue_mode;
  logic wr_ctrl, wr_stat, wr_cmd, cap_rd, hold_rd;
  logic move, cap_we, latch_xfer, hold_we;
  logic flag_set, flag_clr;

  assign ctrl = ctrl_t'(ctrl_raw_q[CTRL_W-1:0]);

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  cap_filter #(.BASE(DLY_BASE)) u_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dly_i (ctrl.dly),
    .lvl_i (pin_s),
    .lvl_o (pin_f)
  );

  cap_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pin_f),
    .sel_i (ctrl.edge_sel),
    .hit_o (hit),
    .rise_o(rise)
  );

  assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_W'(ADR_CTRL));
  assign wr_stat = reg_we_i && (reg_addr_i == ADDR_W'(ADR_STAT));
  assign wr_cmd  = reg_we_i && (reg_addr_i == ADDR_W'(ADR_CMD));
  assign cap_rd  = reg_re_i && (reg_addr_i == ADDR_W'(ADR_CAP));
  assign hold_rd = reg_re_i && (reg_addr_i == ADDR_W'(ADR_HOLD));

  assign queue_mode = !ctrl.latch_mode;

  // queue: push old capture unless protection would overwrite an unread hold
  assign move = queue_mode && hit &&
                (!ctrl.no_ovw || (cap_full_q && !hold_full_q));

  always_comb begin
    if (!hit)                cap_we = 1'b0;
    else if (!ctrl.no_ovw)   cap_we = 1'b1;
    else if (queue_mode)     cap_we = !cap_full_q || move;
    else                     cap_we = !cap_full_q;
  end

  assign latch_xfer = ctrl.latch_mode && (latch_stb_i || (wr_cmd && reg_wdata_i[0])) &&
                      (!ctrl.no_ovw || !hold_full_q);
  assign hold_we    = move || latch_xfer;

  assign flag_set = (queue_mode && ctrl.flag_mode) ? move : cap_we;
  assign flag_clr = (wr_stat && reg_wdata_i[0]) || (cap_rd && ctrl.fast_clr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_raw_q  <= '0;
      cap_q       <= '0;
      hold_q      <= '0;
      cap_full_q  <= 1'b0;
      hold_full_q <= 1'b0;
      flag_q      <= 1'b0;
      pol_q       <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_raw_q <= reg_wdata_i;
      if (hold_we) hold_q <= cap_q;
      if (cap_we) begin
        cap_q <= count_i;
        pol_q <= rise;
      end
      if (cap_we)                     cap_full_q <= 1'b1;
      else if (cap_rd || latch_xfer)  cap_full_q <= 1'b0;
      if (hold_we)                    hold_full_q <= 1'b1;
      else if (hold_rd)               hold_full_q <= 1'b0;
      flag_q <= flag_set | (flag_q & ~flag_clr);
    end
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_W'(ADR_CTRL): reg_rdata_o = ctrl_raw_q;
      ADDR_W'(ADR_STAT): reg_rdata_o = CNT_W'({pol_q, flag_q});
      ADDR_W'(ADR_CAP):  reg_rdata_o = cap_q;
      ADDR_W'(ADR_HOLD): reg_rdata_o = hold_q;
      default:           reg_rdata_o = '0;
    endcase
  end

  assign cap_o  = cap_q;
  assign hold_o = hold_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ctrl.irq_en;
  assign pol_o  = pol_q;

  // R2: disabled edge control never writes the capture register
  a_r2_off_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.edge_sel == EDGE_OFF) |-> !cap_we);

  // R5 / R6: hold only ever receives the prior capture value
  a_r5_hold_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_we |=> (hold_q == $past(cap_q)));

  // R6: without a transfer the holding register keeps its value
  a_r6_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_we |=> $stable(hold_q));

  // R8: protected unread capture survives new edges
  a_r8_cap_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.no_ovw && cap_full_q && !move && !cap_rd && !latch_xfer) |=> $stable(cap_q));

  // R12: set beats a same-cycle clear
  a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set |=> flag_q);
endmodule

// File: tb/cap_channel_bench.sv
module cap_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] cnt_r = '0;
  logic        stb = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, cap, hold;
  logic        flag, irq, pol;

  int total = 0;
  int bad   = 0;

  typedef struct {
    string       req;
    logic [15:0] val;
  } exp_t;
  exp_t exp_q[$];

  logic [15:0] model_cap  = '0;
  logic [15:0] model_hold = '0;
  logic [15:0] last_cap   = '0;
  logic [15:0] tmp;

  always #5 clk = ~clk;
  always @(posedge clk) cnt_r <= cnt_r + 16'd1;

  cap_channel u_cap_channel (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pin_i      (pin),
    .count_i    (cnt_r),
    .latch_stb_i(stb),
    .reg_we_i   (we),
    .reg_re_i   (re),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .cap_o      (cap),
    .hold_o     (hold),
    .flag_o     (flag),
    .irq_o      (irq),
    .pol_o      (pol)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // monitor: each change of the capture register consumes one expected item
  always @(negedge clk) begin
    if (rst_n && cap !== last_cap) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3", "unexpected capture", cap, last_cap);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cap === e.val, e.req, "capture value", cap, e.val);
      end
      last_cap = cap;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  // driver: change the pin now and push the expected timestamp
  task automatic drive(input logic val, input int lat, input bit capx,
                       input bit mv, input string req);
    exp_t e;
    pin = val;
    if (capx) begin
      if (mv) model_hold = model_cap;
      model_cap = cnt_r + 16'(lat);
      e.req = req; e.val = model_cap;
      exp_q.push_back(e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", total, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk(cap == 0 && hold == 0, "R1", "cap/hold reset", cap, 16'h0);
    chk({flag, irq, pol} == 3'b000, "R1", "flag/irq/pol reset", {13'b0, flag, irq, pol}, 16'h0);
    rd(3'd0, tmp);
    chk(tmp == 16'h0, "R1", "ctrl reset", tmp, 16'h0);
    drive(1'b1, 0, 1'b0, 1'b0, "R1"); cyc(6);
    chk(flag == 1'b0 && cap == 0, "R2", "edge off ignores pin", cap, 16'h0);
    drive(1'b0, 0, 1'b0, 1'b0, "R1"); cyc(6);

    // R3 R4 R10 rising only, queue
    wr(3'd0, 16'h0001);
    drive(1'b1, 2, 1'b1, 1'b1, "R3"); cyc(5);
    chk(flag == 1'b1, "R3", "flag after capture", {15'b0, flag}, 16'h1);
    chk(irq == 1'b0, "R4", "irq masked", {15'b0, irq}, 16'h0);
    rd(3'd1, tmp);
    chk(tmp[1] == 1'b1 && pol == 1'b1, "R10", "rising polarity", tmp, 16'h3);
    wr(3'd0, 16'h0005);
    chk(irq == 1'b1, "R4", "irq enabled", {15'b0, irq}, 16'h1);
    drive(1'b0, 0, 1'b0, 1'b0, "R2"); cyc(5);
    chk(cap == model_cap, "R2", "falling ignored in rise mode", cap, model_cap);
    wr(3'd1, 16'h0000);
    chk(flag == 1'b1, "R11", "write 0 keeps flag", {15'b0, flag}, 16'h1);
    wr(3'd1, 16'h0001);
    chk(flag == 1'b0 && irq == 1'b0, "R11", "write 1 clears flag", {14'b0, flag, irq}, 16'h0);

    // R2 falling only
    wr(3'd0, 16'h0002);
    drive(1'b1, 0, 1'b0, 1'b0, "R2"); cyc(5);
    chk(flag == 1'b0, "R2", "rising ignored in fall mode", {15'b0, flag}, 16'h0);
    drive(1'b0, 2, 1'b1, 1'b1, "R2"); cyc(5);
    chk(pol == 1'b0, "R10", "falling polarity", {15'b0, pol}, 16'h0);
    chk(hold == model_hold, "R5", "queue push on fall", hold, model_hold);

    // R2 R5 any edge
    wr(3'd0, 16'h0003);
    drive(1'b1, 2, 1'b1, 1'b1, "R2"); cyc(5);
    chk(hold == model_hold, "R5", "queue push 1", hold, model_hold);
    drive(1'b0, 2, 1'b1, 1'b1, "R5"); cyc(5);
    chk(hold == model_hold, "R5", "queue push 2", hold, model_hold);

    // R6 latch mode
    wr(3'd0, 16'h000B);
    wr(3'd1, 16'h0001);
    drive(1'b1, 2, 1'b1, 1'b0, "R6"); cyc(5);
    drive(1'b0, 2, 1'b1, 1'b0, "R6"); cyc(5);
    chk(hold == model_hold, "R6", "edges leave hold", hold, model_hold);
    chk(flag == 1'b1, "R6", "flag in latch mode", {15'b0, flag}, 16'h1);
    stb = 1'b1; cyc(1); stb = 1'b0; cyc(2);
    model_hold = model_cap;
    chk(hold == model_hold, "R6", "strobe latches", hold, model_hold);
    drive(1'b1, 2, 1'b1, 1'b0, "R6"); cyc(5);
    wr(3'd2, 16'h0001); cyc(1);
    model_hold = model_cap;
    chk(hold == model_hold, "R6", "force latch", hold, model_hold);

    // R12 capture + strobe + flag clear in one cycle
    model_hold = model_cap;
    drive(1'b0, 2, 1'b1, 1'b0, "R12");
    cyc(2);
    stb = 1'b1; we = 1'b1; addr = 3'd1; wdata = 16'h0001;
    cyc(1);
    stb = 1'b0; we = 1'b0;
    cyc(2);
    chk(hold == model_hold, "R12", "hold takes old capture", hold, model_hold);
    chk(cap == model_cap, "R12", "cap takes new value", cap, model_cap);
    chk(flag == 1'b1, "R12", "set wins over clear", {15'b0, flag}, 16'h1);

    // R8 no-overwrite, queue
    wr(3'd0, 16'h0013);
    rd(3'd3, tmp);
    chk(flag == 1'b1, "R11", "read without fast clear keeps flag", {15'b0, flag}, 16'h1);
    rd(3'd4, tmp);
    drive(1'b1, 2, 1'b1, 1'b0, "R8"); cyc(5);
    chk(hold == model_hold, "R8", "empty cap fills without push", hold, model_hold);
    drive(1'b0, 2, 1'b1, 1'b1, "R8"); cyc(5);
    drive(1'b1, 2, 1'b0, 1'b0, "R8"); cyc(5);
    chk(cap == model_cap && hold == model_hold, "R8", "both full drops edge", cap, model_cap);
    rd(3'd4, tmp);
    chk(tmp == model_hold, "R8", "hold readback", tmp, model_hold);
    drive(1'b0, 2, 1'b1, 1'b1, "R8"); cyc(5);
    chk(hold == model_hold, "R8", "freed hold accepts push", hold, model_hold);

    // R9 flag mode
    wr(3'd0, 16'h0033);
    rd(3'd3, tmp);
    rd(3'd4, tmp);
    wr(3'd1, 16'h0001);
    drive(1'b1, 2, 1'b1, 1'b0, "R9"); cyc(5);
    chk(flag == 1'b0, "R9", "capture without transfer", {15'b0, flag}, 16'h0);
    drive(1'b0, 2, 1'b1, 1'b1, "R9"); cyc(5);
    chk(flag == 1'b1, "R9", "transfer sets flag", {15'b0, flag}, 16'h1);

    // R11 fast clear
    wr(3'd0, 16'h0043);
    rd(3'd3, tmp); cyc(1);
    chk(flag == 1'b0, "R11", "fast clear on read", {15'b0, flag}, 16'h0);

    // R7 filter 256
    wr(3'd0, 16'h0083);
    drive(1'b1, 0, 1'b0, 1'b0, "R7"); cyc(100);
    drive(1'b0, 0, 1'b0, 1'b0, "R7"); cyc(300);
    chk(flag == 1'b0 && cap == model_cap, "R7", "short high rejected", cap, model_cap);
    drive(1'b1, 258, 1'b1, 1'b1, "R7"); cyc(262);
    chk(flag == 1'b1, "R7", "long high accepted", {15'b0, flag}, 16'h1);
    // R7 filter 512
    wr(3'd0, 16'h0103);
    wr(3'd1, 16'h0001);
    drive(1'b0, 0, 1'b0, 1'b0, "R7"); cyc(400);
    drive(1'b1, 0, 1'b0, 1'b0, "R7"); cyc(600);
    chk(flag == 1'b0, "R7", "short low rejected", {15'b0, flag}, 16'h0);
    drive(1'b0, 514, 1'b1, 1'b1, "R7"); cyc(520);
    // R7 filter 1024
    wr(3'd0, 16'h0183);
    drive(1'b1, 1026, 1'b1, 1'b1, "R7"); cyc(1032);
    chk(hold == model_hold, "R7", "filtered queue push", hold, model_hold);

    cyc(2);
    chk(exp_q.size() == 0, "R3", "all expected captures seen", 16'(exp_q.size()), 16'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule